// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a blocking data cache that sits between a processor load/store port and a slow memory port. It holds 1024 lines of four 32-bit words. Each line has one tag, one valid flag and one dirty flag. A processor access is taken while the controller is idle. The controller then checks the line that the address selects. A hit completes the access at once. A miss on a dirty line first sends the old line back to memory as one 128-bit transfer. The controller then fetches the new line and retries the access, which now hits.

Writes update only the cache and mark the line dirty. A write miss first brings the line in and then merges the word. The memory port moves a whole line per transfer, and a transfer ends when memory raises its ready. The processor holds its request until it sees ready, and the cache serves one access at a time.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset, cpu_ready and mem_valid are low and every line is invalid. The first access to any address therefore misses, including an address whose tag field is zero.
- R2: The byte address splits into a tag in bits 31..14, a line index in bits 13..4 and a word select in bits 3..2. Lines at different indices never disturb one another.
- R3: A read hit raises cpu_ready in the cycle after the request is accepted and returns the selected word. It makes no memory transfer.
- R4: A write hit stores the word in the cache only and marks the line dirty. It makes no memory transfer, and a later read of that address returns the new value.
- R5: A miss on a line that is clean or invalid makes exactly one memory read, of the aligned line address {addr[31:4], 4'b0000}. The access then completes as a hit in the cycle after memory's ready is accepted.
- R6: A miss on a valid dirty line first writes the old 128-bit line to {stored tag, index, 4'b0000}, with no refill before that write is accepted. The refill read follows, and the written-back data is what memory returns later.
- R7: A write miss fetches the line, then merges the word (write-allocate). The other words of the line keep the memory values, and the line becomes dirty.
- R8: cpu_ready is a single-cycle pulse. It stays low until the access completes, and mem_valid is low in that cycle.
- R9: Within the 128-bit line data, word k (addr[3:2] = k) occupies bits 32k+31..32k on both mem_rdata and mem_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with cpu_ready |
| cpu_ready | output | 1 | Access complete |
| mem_valid | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line written back |
| mem_rdata | input | 128 | Line fetched |
| mem_ready | input | 1 | Memory transfer complete |

## Verification
The request is presented just after a rising edge, and the bench counts falling edges until cpu_ready. A hit completes on the second falling edge. A clean miss adds the compare cycle plus L+1 cycles for the fetch, where L is the memory model's wait, for L+4 edges. A dirty miss adds another L+1 for the write-back, for 2L+5 edges. The driver predicts hit, clean miss or dirty miss from its own shadow of tags and dirty flags, and queues the latency and data it expects. A monitor samples on falling edges, where every registered output has settled, and pops and compares each entry as the pulse appears. The driver also checks the memory-transfer counters and the write-back address after each access.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int INDEX_W = 10,
  parameter int OFFS_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_valid,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [WORD_W-1:0]    cpu_wdata,
  output logic [WORD_W-1:0]    cpu_rdata,
  output logic                 cpu_ready,
  output logic                 mem_valid,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [((1<<OFFS_W)*8)-1:0] mem_wdata,
  input  logic [((1<<OFFS_W)*8)-1:0] mem_rdata,
  input  logic                 mem_ready
);
  localparam int LINE_W = (1 << OFFS_W) * 8;
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int SEL_W  = $clog2(WORDS);
  localparam int BYTE_W = OFFS_W - SEL_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - OFFS_W;
  localparam int SETS   = 1 << INDEX_W;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CMP   = 2'd1,
    S_WB    = 2'd2,
    S_ALLOC = 2'd3
  } state_t;

  state_t state_q, state_d;

  logic [ADDR_W-1:0] req_addr_q;
  logic              req_we_q;
  logic [WORD_W-1:0] req_wdata_q;

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  logic [INDEX_W-1:0] idx;
  logic [TAG_W-1:0]   req_tag;
  logic [SEL_W-1:0]   sel;
  logic [LINE_W-1:0]  line;
  logic               hit;
  logic               victim_dirty;

  assign idx          = req_addr_q[OFFS_W +: INDEX_W];
  assign req_tag      = req_addr_q[ADDR_W-1 -: TAG_W];
  assign sel          = req_addr_q[BYTE_W +: SEL_W];
  assign line         = data_q[idx];
  assign hit          = valid_q[idx] && (tag_q[idx] == req_tag);
  assign victim_dirty = valid_q[idx] && dirty_q[idx];

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (cpu_valid) state_d = S_CMP;
      S_CMP:   if (hit) state_d = S_IDLE;
               else if (victim_dirty) state_d = S_WB;
               else state_d = S_ALLOC;
      S_WB:    if (mem_ready) state_d = S_ALLOC;
      S_ALLOC: if (mem_ready) state_d = S_CMP;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      req_addr_q  <= '0;
      req_we_q    <= 1'b0;
      req_wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && cpu_valid) begin
        req_addr_q  <= cpu_addr;
        req_we_q    <= cpu_we;
        req_wdata_q <= cpu_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (state_q == S_ALLOC && mem_ready) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (state_q == S_CMP && hit && req_we_q) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == S_ALLOC && mem_ready) begin
      tag_q[idx]  <= req_tag;
      data_q[idx] <= mem_rdata;
    end else if (state_q == S_CMP && hit && req_we_q) begin
      data_q[idx][sel*WORD_W +: WORD_W] <= req_wdata_q;
    end
  end

  assign cpu_ready = (state_q == S_CMP) && hit;
  assign cpu_rdata = line[sel*WORD_W +: WORD_W];
  assign mem_valid = (state_q == S_WB) || (state_q == S_ALLOC);
  assign mem_we    = (state_q == S_WB);
  assign mem_addr  = (state_q == S_WB) ? {tag_q[idx], idx, {OFFS_W{1'b0}}}
                                       : {req_tag, idx, {OFFS_W{1'b0}}};
  assign mem_wdata = line;

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_ready_quiet_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_valid);

  p_wb_then_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && mem_ready) |=> (mem_valid && !mem_we));

  p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  p_refill_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && mem_ready) |=> cpu_ready);
endmodule

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
  localparam int L = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_valid = 1'b0;
  logic         cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready;
  logic         mem_valid;
  logic         mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  always #2.5 clk = ~clk;

  dm_wb_cache u_dm_wb_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int tests = 0;
  int fails = 0;

  function automatic logic [31:0] iw(input logic [31:0] wa);
    return (wa * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [127:0] iline(input logic [31:0] la);
    logic [127:0] v;
    for (int k = 0; k < 4; k++) v[k*32 +: 32] = iw(la * 4 + k);
    return v;
  endfunction

  // backing memory model, keyed by line number
  logic [127:0] bmem [int unsigned];
  int           wait_c = 0;
  int           rd_cnt = 0;
  int           wb_cnt = 0;
  logic [31:0]  last_wb_addr = '0;

  always @(posedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
      if (mem_we) begin
        bmem[mem_addr >> 4] = mem_wdata;
        wb_cnt <= wb_cnt + 1;
        last_wb_addr <= mem_addr;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end else if (mem_valid) begin
      if (wait_c == L - 1) begin
        wait_c <= 0;
        mem_ready <= 1'b1;
        mem_rdata <= bmem.exists(mem_addr >> 4) ? bmem[mem_addr >> 4] : iline(mem_addr >> 4);
      end else begin
        wait_c <= wait_c + 1;
      end
    end
  end

  // golden word store and shadow of tag state
  logic [31:0] gold [int unsigned];
  logic [17:0] s_tag [1024];
  logic        s_val [1024];
  logic        s_dty [1024];

  int    q_lat [$];
  logic [31:0] q_dat [$];
  bit    q_chk [$];
  string q_req [$];
  bit    done = 1'b0;
  int    cyc = 0;

  always @(negedge clk) begin
    if (cpu_valid) cyc = cyc + 1;
    if (cpu_ready && q_lat.size() > 0) begin
      int el; logic [31:0] ed; bit ec; string er;
      el = q_lat.pop_front(); ed = q_dat.pop_front();
      ec = q_chk.pop_front(); er = q_req.pop_front();
      tests++;
      if (cyc != el) begin
        fails++;
        $display("FAIL %s latency: actual %0d expected %0d", er, cyc, el);
      end
      if (ec) begin
        tests++;
        if (cpu_rdata !== ed) begin
          fails++;
          $display("FAIL %s read data: actual %h expected %h", er, cpu_rdata, ed);
        end
      end
      cyc = 0;
      done = 1'b1;
    end
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd);
    int idx; logic [17:0] tg; bit h; bit d; int rd0; int wb0;
    logic [31:0] wba; string r;
    idx = int'(a[13:4]); tg = a[31:14];
    h = s_val[idx] && s_tag[idx] == tg;
    d = !h && s_val[idx] && s_dty[idx];
    wba = {s_tag[idx], a[13:4], 4'b0000};
    r = h ? (we ? "R4" : "R3") : (d ? "R6" : (we ? "R7" : "R5"));
    if (!h) begin s_tag[idx] = tg; s_val[idx] = 1'b1; s_dty[idx] = 1'b0; end
    if (we) begin s_dty[idx] = 1'b1; gold[a >> 2] = wd; end
    q_lat.push_back(h ? 2 : (d ? 2*L + 5 : L + 4));
    q_dat.push_back(gold.exists(a >> 2) ? gold[a >> 2] : iw(a >> 2));
    q_chk.push_back(!we);
    q_req.push_back(r);
    rd0 = rd_cnt; wb0 = wb_cnt;
    @(posedge clk); #1;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    wait (done);
    done = 1'b0;
    cpu_valid = 1'b0;
    check({r, " fetch count"}, rd_cnt - rd0, h ? 0 : 1);
    check({r, " write-back count"}, wb_cnt - wb0, d ? 1 : 0);
    if (d) check("R6 write-back address", last_wb_addr, wba);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin s_val[i] = 0; s_dty[i] = 0; s_tag[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1 cpu_ready in reset", {31'b0, cpu_ready}, 32'd0);
    check("R1 mem_valid in reset", {31'b0, mem_valid}, 32'd0);
    rst_n = 1'b1;
    // R1: tag-zero line still misses after reset
    access(0, 32'h0000_0000, 0);
    // R3 hits, R9 word placement via word selects
    access(0, 32'h0000_0000, 0);
    access(0, 32'h0000_0008, 0);
    access(0, 32'h0000_000C, 0);
    // R4 write hit then read back
    access(1, 32'h0000_0004, 32'hCAFE_0004);
    access(0, 32'h0000_0004, 0);
    // R6 conflicting tag on index 0 evicts dirty line
    access(0, 32'h0000_4000, 0);
    access(0, 32'h0000_0004, 0);
    // R7 write miss allocates and merges
    access(1, 32'h1234_5678, 32'hBEEF_1234);
    access(0, 32'h1234_5678, 0);
    access(0, 32'h1234_5670, 0);
    access(0, 32'h1234_5678 ^ 32'h0000_4000, 0);
    access(0, 32'h1234_5678, 0);
    // R2 top index and distinct indices stay separate
    access(1, 32'hFFFF_FFFC, 32'h0BAD_F00D);
    for (int i = 1; i < 6; i++) access(1, 32'h0000_0000 + i * 16, 32'h1000_0000 + i);
    for (int i = 1; i < 6; i++) access(0, 32'h0000_0000 + i * 16, 0);
    access(0, 32'hFFFF_FFFC, 0);
    // R6 several dirty evictions in a row on one index
    for (int i = 0; i < 4; i++) access(1, 32'h0000_0020 + i * 32'h4000, 32'h2000_0000 + i);
    for (int i = 0; i < 4; i++) access(0, 32'h0000_0020 + i * 32'h4000, 0);
    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule